// File: doc/BRIEF.md
# Prescaled Tick and Alarm Timer

This block keeps time from the main clock. A free-running divide-by-64 stage feeds a 20-bit down-divider. The down-divider reloads from a software-set value each time it reaches zero. The pulse it produces there is the basic tick. Each tick advances a 32-bit time counter, and a tick that brings the counter to the alarm value sets the alarm flag. The /64 stage, the 20-bit divider and the 32-bit counter together span a 58-bit timing chain.

Software reaches every register in 16-bit halves over a plain register bus. Writes are synchronous and reads are combinational. There are two interrupt requests, one per tick and one on an alarm match. Each request has a sticky flag that is cleared by writing a one, and a separate enable. A control bit stops the whole counting chain, which stands in for turning the oscillator off.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset every register reads 0, both interrupt outputs are low and the chain runs.
- R2: The tick period is (reload+1)*64 clock cycles. A new reload value takes effect at the next tick boundary.
- R3: The reload upper half holds 4 bits, and a read of it returns zeros above bit 3.
- R4: The time counter increments by one on each tick and wraps from 0xFFFFFFFF to 0.
- R5: A write to either time half shows on the next clock. A tick in the same cycle as the write is lost, so the written value stands.
- R6: The alarm flag (flags bit 1) is set when a tick brings the counter to the alarm value. It is set once for each match.
- R7: The tick flag (flags bit 0) is set on every tick. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R8: `irq_tick` equals the tick flag AND control bit 1. `irq_alarm` equals the alarm flag AND control bit 2.
- R9: Control bit 0 set to 1 freezes the /64 stage, the divider and the time counter.
- R10: Register addresses are: 0 control, 1 flags, 2 and 3 reload low and high, 4 and 5 time low and high, 6 and 7 alarm low and high. Each writable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_tick | output | 1 | Tick interrupt request |
| irq_alarm | output | 1 | Alarm interrupt request |

## Verification
The assertions assume two things: `bus_wr` is never X after reset, and every write lasts exactly one cycle. The bench drives every write as a single-cycle strobe at a falling edge.

The tick-spacing assertion also assumes the smallest period of 64 cycles, which holds for any reload value. For the write-against-tick collision, the bench first finds the tick phase by polling the tick flag. It then counts 63 cycles and places a time write on the exact edge of the next tick.

// File: rtl/tat_pkg.sv
package tat_pkg;
    localparam int PRE_W  = 6;
    localparam int DIV_W  = 20;
    localparam int CNT_W  = 32;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam int NUM_IRQ = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 3'd0,
        A_FLAGS   = 3'd1,
        A_RLD_LO  = 3'd2,
        A_RLD_HI  = 3'd3,
        A_TIME_LO = 3'd4,
        A_TIME_HI = 3'd5,
        A_ALM_LO  = 3'd6,
        A_ALM_HI  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic alarm_ie;
        logic tick_ie;
        logic osc_off;
    } ctrl_t;
endpackage

// File: rtl/tat_divider.sv
module tat_divider #(
    parameter int PRE_W = tat_pkg::PRE_W,
    parameter int DIV_W = tat_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    stage_end;

    always_comb begin
        st_d      = st_q;
        stage_end = run_i && (&st_q.pre);
        tick_o    = stage_end && (st_q.div == '0);
        if (run_i) begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (stage_end) begin
            st_d.div = (st_q.div == '0) ? reload_i : st_q.div - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
endmodule

// File: rtl/tat_timecnt.sv
module tat_timecnt #(
    parameter int CNT_W = tat_pkg::CNT_W,
    parameter int HW    = tat_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [HW-1:0]    wdata_i,
    input  logic [CNT_W-1:0] alarm_i,
    output logic [CNT_W-1:0] time_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] time_d, time_q, incr;

    always_comb begin
        time_d = time_q;
        incr   = time_q + 1'b1;
        hit_o  = 1'b0;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) time_d[HW-1:0]     = wdata_i;
            if (wr_hi_i) time_d[CNT_W-1:HW] = wdata_i[CNT_W-HW-1:0];
        end else if (tick_i) begin
            time_d = incr;
            hit_o  = (incr == alarm_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else begin
            time_q <= time_d;
        end
    end

    assign time_o = time_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_lo_i && !wr_hi_i && (&time_q)) |=> (time_q == '0)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (time_q[HW-1:0] == $past(wdata_i))); // R5
    AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (time_q == $past(alarm_i))); // R6
endmodule

// File: rtl/tat_flag.sv
module tat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

    AST_FLAG_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_i)); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R7
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
    import tat_pkg::*;
#(
    parameter int PRE_BITS  = tat_pkg::PRE_W,
    parameter int DIV_BITS  = tat_pkg::DIV_W,
    parameter int CNT_BITS  = tat_pkg::CNT_W,
    parameter int BUS_BITS  = tat_pkg::BUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_BITS-1:0] bus_wdata,
    output logic [BUS_BITS-1:0] bus_rdata,
    output logic                irq_tick,
    output logic                irq_alarm
);
    localparam int RHI_W = DIV_BITS - BUS_BITS;
    localparam int THI_W = CNT_BITS - BUS_BITS;

    typedef struct packed {
        ctrl_t               ctrl;
        logic [DIV_BITS-1:0] reload;
        logic [CNT_BITS-1:0] alarm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic                tick, hit;
    logic                wr_time_lo, wr_time_hi;
    logic [CNT_BITS-1:0] time_val;
    logic [NUM_IRQ-1:0]  set_v, clr_v, en_v, flag_v, irq_v;

    always_comb begin
        cfg_d      = cfg_q;
        wr_time_lo = bus_wr && (bus_addr == A_TIME_LO);
        wr_time_hi = bus_wr && (bus_addr == A_TIME_HI);
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                A_CTRL:   cfg_d.ctrl = bus_wdata[$bits(ctrl_t)-1:0];
                A_RLD_LO: cfg_d.reload[BUS_BITS-1:0] = bus_wdata;
                A_RLD_HI: cfg_d.reload[DIV_BITS-1:BUS_BITS] = bus_wdata[RHI_W-1:0];
                A_ALM_LO: cfg_d.alarm[BUS_BITS-1:0] = bus_wdata;
                A_ALM_HI: cfg_d.alarm[CNT_BITS-1:BUS_BITS] = bus_wdata[THI_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    tat_divider #(.PRE_W(PRE_BITS), .DIV_W(DIV_BITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (!cfg_q.ctrl.osc_off),
        .reload_i (cfg_q.reload),
        .tick_o   (tick)
    );

    tat_timecnt #(.CNT_W(CNT_BITS), .HW(BUS_BITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_lo_i (wr_time_lo),
        .wr_hi_i (wr_time_hi),
        .wdata_i (bus_wdata),
        .alarm_i (cfg_q.alarm),
        .time_o  (time_val),
        .hit_o   (hit)
    );

    assign set_v = {hit, tick};
    assign en_v  = {cfg_q.ctrl.alarm_ie, cfg_q.ctrl.tick_ie};

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign clr_v[i] = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[i];
        tat_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .en_i   (en_v[i]),
            .flag_o (flag_v[i]),
            .irq_o  (irq_v[i])
        );
    end

    assign irq_tick  = irq_v[0];
    assign irq_alarm = irq_v[1];

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_CTRL:    bus_rdata = BUS_BITS'(cfg_q.ctrl);
            A_FLAGS:   bus_rdata = BUS_BITS'(flag_v);
            A_RLD_LO:  bus_rdata = cfg_q.reload[BUS_BITS-1:0];
            A_RLD_HI:  bus_rdata = BUS_BITS'(cfg_q.reload[DIV_BITS-1:BUS_BITS]);
            A_TIME_LO: bus_rdata = time_val[BUS_BITS-1:0];
            A_TIME_HI: bus_rdata = BUS_BITS'(time_val[CNT_BITS-1:BUS_BITS]);
            A_ALM_LO:  bus_rdata = cfg_q.alarm[BUS_BITS-1:0];
            default:   bus_rdata = BUS_BITS'(cfg_q.alarm[CNT_BITS-1:BUS_BITS]);
        endcase
    end

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ctrl.osc_off && !wr_time_lo && !wr_time_hi) |=> $stable(time_val)); // R9
    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ctrl.osc_off |-> !tick); // R9
endmodule

// File: tb/test_tick_alarm_timer.sv
module test_tick_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_tick, irq_alarm;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 irq_tick, 2 irq_alarm
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cycle++;

    tick_alarm_timer i_tick_alarm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_tick  (irq_tick),
        .irq_alarm (irq_alarm)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {15'd0, irq_tick};
                    default: act = {15'd0, irq_alarm};
                endcase
                check(32'(act), 32'(it.exp), it.req);
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [15:0] e, input string req);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = 0; it.exp = e; it.req = req;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic expect_irq(input int k, input logic e, input string req);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = {15'd0, e}; it.req = req;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_time_lo(input logic [15:0] v);
        forever begin
            @(negedge clk);
            bus_addr = 3'd4;
            #1;
            if (bus_rdata == v) break;
        end
    endtask

    task automatic wait_time_change(output int at);
        logic [15:0] old;
        @(negedge clk);
        bus_addr = 3'd4;
        #1;
        old = bus_rdata;
        forever begin
            @(negedge clk);
            #1;
            if (bus_rdata != old) break;
        end
        at = cycle;
    endtask

    initial begin
        int t0, t1, t2;
        logic [15:0] frozen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(3'd0, 16'h0000, "R1 ctrl");
        expect_reg(3'd1, 16'h0000, "R1 flags");
        expect_reg(3'd2, 16'h0000, "R1 reload");
        expect_reg(3'd7, 16'h0000, "R1 alarm hi");
        expect_irq(1, 1'b0, "R1 irq_tick");
        expect_irq(2, 1'b0, "R1 irq_alarm");

        // R10 / R3 readback
        wr(3'd0, 16'h0001);
        wr(3'd6, 16'hA5C3);
        wr(3'd7, 16'h3C5A);
        wr(3'd3, 16'hFFFF);
        expect_reg(3'd0, 16'h0001, "R10 ctrl");
        expect_reg(3'd6, 16'hA5C3, "R10 alarm lo");
        expect_reg(3'd7, 16'h3C5A, "R10 alarm hi");
        expect_reg(3'd3, 16'h000F, "R3 reload hi masked");
        wr(3'd3, 16'h0000);

        // R9 freeze
        wr(3'd4, 16'h1234);
        expect_reg(3'd4, 16'h1234, "R5 time lo write");
        @(negedge clk); bus_addr = 3'd4; #1; frozen = bus_rdata;
        repeat (300) @(negedge clk);
        expect_reg(3'd4, frozen, "R9 frozen");

        // R2 period with reload 2
        wr(3'd2, 16'h0002);
        wr(3'd0, 16'h0000);
        wait_time_change(t0);
        wait_time_change(t1);
        wait_time_change(t2);
        check(32'(t2 - t1), 32'd192, "R2 period reload 2");
        wr(3'd2, 16'h0000);
        wait_time_change(t0);
        wait_time_change(t1);
        wait_time_change(t2);
        check(32'(t2 - t1), 32'd64, "R2 period reload 0");

        // R4 wrap
        wr(3'd0, 16'h0001);
        wr(3'd5, 16'hFFFF);
        wr(3'd4, 16'hFFFF);
        expect_reg(3'd5, 16'hFFFF, "R5 time hi write");
        wr(3'd0, 16'h0000);
        wait_time_lo(16'h0000);
        expect_reg(3'd5, 16'h0000, "R4 wrap hi");
        expect_reg(3'd4, 16'h0000, "R4 wrap lo");

        // R6 alarm, R8 gating
        wr(3'd0, 16'h0001);
        wr(3'd5, 16'h0000);
        wr(3'd4, 16'h0001);
        wr(3'd6, 16'h0003);
        wr(3'd7, 16'h0000);
        wr(3'd1, 16'h0003);
        expect_reg(3'd1, 16'h0000, "R7 flags cleared");
        wr(3'd0, 16'h0004);
        wait_time_lo(16'h0003);
        expect_reg(3'd1, 16'h0003, "R6 alarm flag on match");
        expect_irq(2, 1'b1, "R8 irq_alarm enabled");
        expect_irq(1, 1'b0, "R8 irq_tick masked");
        wr(3'd0, 16'h0006);
        expect_irq(1, 1'b1, "R8 irq_tick enabled");
        wr(3'd1, 16'h0000);
        expect_reg(3'd1, 16'h0003, "R7 write 0 no effect");
        wr(3'd1, 16'h0002);
        expect_irq(2, 1'b0, "R7 alarm flag cleared");
        wait_time_lo(16'h0006);
        expect_reg(3'd1, 16'h0001, "R6 fires once");

        // R5 collision: find tick phase, write on the next tick edge
        wr(3'd1, 16'h0001);
        forever begin
            @(negedge clk);
            bus_addr = 3'd1;
            #1;
            if (bus_rdata[0]) break;
        end
        bus_addr = 3'd1; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (62) @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 16'h0100; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check(32'(bus_rdata), 32'h0100, "R5 write beats tick");
        bus_addr = 3'd1;
        #1;
        check(32'(bus_rdata[0]), 32'd1, "R5 tick did occur");
        wait_time_change(t0);
        expect_reg(3'd4, 16'h0101, "R4 next tick increments");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycle >= 150000);
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected under 150000", cycle);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule